// File: doc/BRIEF.md
# 64-bit Rotate Unit with Carry-Through Mode

This block rotates a 64-bit operand by a variable amount. It has four operations: plain rotate left, plain rotate right, and rotate left or right with the incoming carry flag inserted into the ring as a 65th bit. One input picks where the rotate amount comes from: an immediate field, a register field, or the constant one. The amount is always reduced to its low six bits. When the reduced amount is zero, the operation writes nothing and leaves both flags as they were.

Each accepted request is registered. One cycle after the request the unit presents the rotated value, a write-enable for the destination, and the new carry and overflow flags, with a one-cycle valid strobe. Between requests the registered outputs hold their values. The carry and overflow inputs are returned unchanged on the outputs whenever the operation does not define them. All other status flags are handled outside the block.

Top module: `rot_unit`

## Requirements
- R1: The rotate amount n is `imm_cnt[5:0]` when `cnt_src` is 0, the constant 1 when `cnt_src` is 1, and `reg_cnt[5:0]` when `cnt_src` is 2 or 3. The upper bits of both count inputs have no effect.
- R2: When n is 0, `wr_en` is 0, `result` equals the operand, `cf_out` equals `cf_in` and `of_out` equals `of_in`.
- R3: With `op` = 0 (rotate left), `result` is the operand rotated left by n, and `cf_out` equals `result[0]`.
- R4: With `op` = 1 (rotate right), `result` is the operand rotated right by n, and `cf_out` equals `result[63]`.
- R5: With `op` = 2 (left through carry), the 65-bit value {cf_in, operand} is rotated left by n. `result` is its low 64 bits, and `cf_out` is operand bit 64−n. For n = 1 this gives (operand << 1) | cf_in.
- R6: With `op` = 3 (right through carry), the 65-bit value {cf_in, operand} is rotated right by n. `result` is its low 64 bits, and `cf_out` is operand bit n−1. For n = 1 this gives (operand >> 1) | (cf_in << 63).
- R7: When n is 1, `of_out` is 1 exactly when operand bit 63 and result bit 63 differ, for all four operations.
- R8: When n is greater than 1, `of_out` equals `of_in`.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Without a request, `result`, `wr_en`, `cf_out` and `of_out` hold their values.
- R10: While reset is asserted, all outputs are 0.
- R11: When n is nonzero, `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 rotl, 1 rotr, 2 rotl through carry, 3 rotr through carry |
| cnt_src | input | 2 | Amount source: 0 immediate, 1 constant one, 2/3 register |
| imm_cnt | input | 8 | Immediate amount (low 6 bits used) |
| reg_cnt | input | 8 | Register amount (low 6 bits used) |
| operand | input | 64 | Value to rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| wr_en | output | 1 | Destination write enable |
| result | output | 64 | Rotated value |
| cf_out | output | 1 | Outgoing carry flag |
| of_out | output | 1 | Outgoing overflow flag |

## Verification
Every operation is swept over all 64 amounts. The operands used are a value with only its end bits set, an irregular mixed pattern, and the complement of the first. Together they show whether bits wrap at the correct boundary and whether an off-by-one in the amount is present. Both carry-in values are applied, which separates the carry-through rotations from the plain ones and shows whether the carry enters the ring at the right position. The overflow input is driven opposite to the carry input, so a flag that is passed through can be told apart from one that is computed. The amount sources are exercised with nonzero upper bits on the count inputs, and idle cycles confirm that the outputs hold.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    ROT_L  = 2'd0,
    ROT_R  = 2'd1,
    ROT_LC = 2'd2,
    ROT_RC = 2'd3
  } rot_op_e;

  typedef enum logic [1:0] {
    CSRC_IMM   = 2'd0,
    CSRC_ONE   = 2'd1,
    CSRC_REG   = 2'd2,
    CSRC_REG_B = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/rot_barrel.sv
// Logarithmic barrel rotator; direction chosen by parameter.
module rot_barrel #(
  parameter int W    = 64,
  parameter int SH_W = 6,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    if (LEFT) begin : g_left
      assign moved = {stg[k][W-1-S:0], stg[k][W-1:W-S]};
    end else begin : g_right
      assign moved = {stg[k][S-1:0], stg[k][W-1:S]};
    end
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/rot_count_sel.sv
// Selects and masks the rotate amount.
module rot_count_sel
  import rot_pkg::*;
#(
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic [1:0]          cnt_src,
  input  logic [CNT_IN_W-1:0] imm_cnt,
  input  logic [CNT_IN_W-1:0] reg_cnt,
  output logic [CNT_W-1:0]    cnt,
  output logic                cnt_zero,
  output logic                cnt_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic unused_hi;
  assign unused_hi = ^{imm_cnt[CNT_IN_W-1:CNT_W], reg_cnt[CNT_IN_W-1:CNT_W]};

  always_comb begin
    unique case (cnt_src_e'(cnt_src))
      CSRC_IMM: cnt = imm_cnt[CNT_W-1:0];
      CSRC_ONE: cnt = ONE;
      default:  cnt = reg_cnt[CNT_W-1:0];
    endcase
  end

  assign cnt_zero = (cnt == '0);
  assign cnt_one  = (cnt == ONE);
endmodule

// File: rtl/rot_core.sv
// Four rotators (plain 64-bit and 65-bit carry ring) plus result select.
module rot_core
  import rot_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6
) (
  input  logic [1:0]        op,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] operand,
  input  logic              cf_in,
  output logic [DATA_W-1:0] rot_res,
  output logic              cf_rot
);
  localparam int RING_W = DATA_W + 1;

  logic [DATA_W-1:0] res_l, res_r;
  logic [RING_W-1:0] ring_in, ring_l, ring_r;

  assign ring_in = {cf_in, operand};

  rot_barrel #(.W(DATA_W), .SH_W(CNT_W), .LEFT(1'b1)) u_rol (
    .din(operand), .amt(cnt), .dout(res_l));
  rot_barrel #(.W(DATA_W), .SH_W(CNT_W), .LEFT(1'b0)) u_ror (
    .din(operand), .amt(cnt), .dout(res_r));
  rot_barrel #(.W(RING_W), .SH_W(CNT_W), .LEFT(1'b1)) u_rcl (
    .din(ring_in), .amt(cnt), .dout(ring_l));
  rot_barrel #(.W(RING_W), .SH_W(CNT_W), .LEFT(1'b0)) u_rcr (
    .din(ring_in), .amt(cnt), .dout(ring_r));

  always_comb begin
    unique case (rot_op_e'(op))
      ROT_L: begin
        rot_res = res_l;
        cf_rot  = res_l[0];
      end
      ROT_R: begin
        rot_res = res_r;
        cf_rot  = res_r[DATA_W-1];
      end
      ROT_LC: begin
        rot_res = ring_l[DATA_W-1:0];
        cf_rot  = ring_l[DATA_W];
      end
      default: begin
        rot_res = ring_r[DATA_W-1:0];
        cf_rot  = ring_r[DATA_W];
      end
    endcase
  end
endmodule

// File: rtl/rot_flags.sv
// Write-enable, carry and overflow next values.
module rot_flags (
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic op_msb,
  input  logic res_msb,
  input  logic cf_rot,
  input  logic cf_in,
  input  logic of_in,
  output logic wr_nx,
  output logic cf_nx,
  output logic of_nx
);
  always_comb begin
    wr_nx = ~cnt_zero;
    cf_nx = cnt_zero ? cf_in : cf_rot;
    of_nx = cnt_one ? (op_msb ^ res_msb) : of_in;
  end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic [1:0]          cnt_src,
  input  logic [CNT_IN_W-1:0] imm_cnt,
  input  logic [CNT_IN_W-1:0] reg_cnt,
  input  logic [DATA_W-1:0]   operand,
  input  logic                cf_in,
  input  logic                of_in,
  output logic                out_valid,
  output logic                wr_en,
  output logic [DATA_W-1:0]   result,
  output logic                cf_out,
  output logic                of_out
);
  localparam int MSB = DATA_W - 1;

  logic [CNT_W-1:0]  cnt;
  logic              cnt_zero, cnt_one;
  logic [DATA_W-1:0] rot_res, res_nx;
  logic              cf_rot, wr_nx, cf_nx, of_nx;

  rot_count_sel #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W)) u_cnt (
    .cnt_src(cnt_src), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
    .cnt(cnt), .cnt_zero(cnt_zero), .cnt_one(cnt_one));

  rot_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .op(op), .cnt(cnt), .operand(operand), .cf_in(cf_in),
    .rot_res(rot_res), .cf_rot(cf_rot));

  always_comb begin
    res_nx = cnt_zero ? operand : rot_res;
  end

  rot_flags u_flags (
    .cnt_zero(cnt_zero), .cnt_one(cnt_one),
    .op_msb(operand[MSB]), .res_msb(rot_res[MSB]),
    .cf_rot(cf_rot), .cf_in(cf_in), .of_in(of_in),
    .wr_nx(wr_nx), .cf_nx(cf_nx), .of_nx(of_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en  <= 1'b0;
      result <= '0;
      cf_out <= 1'b0;
      of_out <= 1'b0;
    end else if (in_valid) begin
      wr_en  <= wr_nx;
      result <= res_nx;
      cf_out <= cf_nx;
      of_out <= of_nx;
    end
  end

  // R9: strobe timing and hold
  a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cf_out) && $stable(of_out)));
  // R2: zero amount leaves destination and flags untouched
  a_r2_zero_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_zero) |=> (!wr_en && result == $past(operand)
                                && cf_out == $past(cf_in) && of_out == $past(of_in)));
  // R11: nonzero amount writes
  a_r11_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cnt_zero) |=> wr_en);
  // R3 / R4: plain rotate carry tracks an end bit of the result
  a_r3_rol_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cnt_zero && op == ROT_L) |=> (cf_out == result[0]));
  a_r4_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cnt_zero && op == ROT_R) |=> (cf_out == result[MSB]));
  // R7 / R8: overflow rules
  a_r7_of_single: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_one) |=> (of_out == (result[MSB] ^ $past(operand[MSB]))));
  a_r8_of_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cnt_zero && !cnt_one) |=> (of_out == $past(of_in)));
endmodule

// File: tb/rot_unit_bench.sv
module rot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    op, cnt_src;
  logic [7:0]    imm_cnt, reg_cnt;
  logic [W-1:0]  operand;
  logic          cf_in, of_in;
  logic          out_valid, wr_en, cf_out, of_out;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_unit u_rot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cnt_src(cnt_src),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .operand(operand), .cf_in(cf_in),
    .of_in(of_in), .out_valid(out_valid), .wr_en(wr_en), .result(result),
    .cf_out(cf_out), .of_out(of_out));

  task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: bit-by-bit placement, {wr, cf, of, result}
  task automatic model(input logic [1:0] o, input int n, input logic [W-1:0] a,
                       input logic c, input logic ov, output logic [W+2:0] e);
    logic [W-1:0] r;
    logic [W:0]   x, y;
    logic         cf, of;
    x = {c, a};
    r = a; cf = c; of = ov;
    if (n != 0) begin
      case (o)
        2'd0: begin for (int i = 0; i < W; i++) r[(i+n)%W] = a[i]; cf = r[0]; end
        2'd1: begin for (int i = 0; i < W; i++) r[i] = a[(i+n)%W]; cf = r[W-1]; end
        2'd2: begin for (int i = 0; i <= W; i++) y[(i+n)%(W+1)] = x[i]; r = y[W-1:0]; cf = y[W]; end
        default: begin for (int i = 0; i <= W; i++) y[i] = x[(i+n)%(W+1)]; r = y[W-1:0]; cf = y[W]; end
      endcase
      of = (n == 1) ? (r[W-1] ^ a[W-1]) : ov;
    end
    e = {(n != 0), cf, of, r};
  endtask

  task automatic run(input string tag, input logic [1:0] o, input logic [1:0] src,
                     input logic [7:0] im, input logic [7:0] rg,
                     input logic [W-1:0] a, input logic c, input logic ov);
    logic [W+2:0] e;
    logic [W+2:0] held;
    int n;
    n = (src == 2'd0) ? int'(im[5:0]) : (src == 2'd1) ? 1 : int'(rg[5:0]);
    model(o, n, a, c, ov, e);
    @(negedge clk);
    op = o; cnt_src = src; imm_cnt = im; reg_cnt = rg; operand = a; cf_in = c; of_in = ov;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    operand = ~a; cf_in = ~c; of_in = ~ov;
    check(tag, {wr_en, cf_out, of_out, result}, e);
    check("R9 strobe", {{(W+2){1'b0}}, out_valid}, {{(W+2){1'b0}}, 1'b1});
    held = {wr_en, cf_out, of_out, result};
    @(negedge clk);
    check("R9 hold", {wr_en, cf_out, of_out, result}, held);
    check("R9 idle", {{(W+2){1'b0}}, out_valid}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [3];
    string tag;
    pats[0] = 64'h8000_0000_0000_0001;
    pats[1] = 64'hDEAD_BEEF_0123_4567;
    pats[2] = 64'h7FFF_FFFF_FFFF_FFFE;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; cnt_src = '0; imm_cnt = '0; reg_cnt = '0;
    operand = '1; cf_in = 1'b1; of_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset", {wr_en, cf_out, of_out, result}, '0);
    check("R10 reset valid", {{(W+2){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;

    // Sweep: all ops, all amounts, three patterns, both carries (upper count bits set)
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 64; n++)
        for (int p = 0; p < 3; p++)
          for (int c = 0; c < 2; c++) begin
            if (n == 0) tag = "R2 zero";
            else if (o == 0) tag = (n == 1) ? "R3 R7 rol" : "R3 R8 rol";
            else if (o == 1) tag = (n == 1) ? "R4 R7 ror" : "R4 R8 ror";
            else if (o == 2) tag = (n == 1) ? "R5 R7 rcl" : "R5 R8 rcl";
            else             tag = (n == 1) ? "R6 R7 rcr" : "R6 R8 rcr R11";
            run(tag, 2'(o), 2'd2, 8'h00, {2'b11, 6'(n)}, pats[p], c[0], ~c[0]);
          end

    // R1: amount sources, upper bits ignored
    run("R1 imm", 2'd0, 2'd0, 8'hC5, 8'h01, pats[1], 1'b0, 1'b0);
    run("R1 imm zero", 2'd1, 2'd0, 8'h40, 8'h07, pats[1], 1'b1, 1'b0);
    run("R1 one", 2'd2, 2'd1, 8'h00, 8'h00, pats[0], 1'b1, 1'b1);
    run("R1 one", 2'd3, 2'd1, 8'h3F, 8'h3F, pats[2], 1'b0, 1'b0);
    run("R1 reg alt", 2'd3, 2'd3, 8'h01, 8'hBF, pats[1], 1'b1, 1'b0);
    run("R1 reg", 2'd1, 2'd2, 8'h09, 8'h80, pats[2], 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule